// File: doc/BRIEF.md
# Data Cache Maintenance Command Unit

This block is the maintenance front end of a small write-back data cache. A processor-side register port takes maintenance commands. Two families exist. Flush writes dirty data back and keeps the line. Invalidate drops the line. Each family can act on the whole cache or on a single line. The block walks its own tag, valid and dirty array. It raises a writeback request for each dirty line that a command must preserve, and it updates the valid and dirty bits as the command requires.

A control register holds the cache-disable bit and the invalidate-mode bit. The same register also shows a read-only busy bit. A per-line command takes its set index from the address written with the command. The tag it matches against comes from a separate physical-tag register, written beforehand. An install port stands in for the refill path so the array can be populated. A probe port exposes one array entry, as the hit path would see it.

Top module: `dcache_maint_unit`

## Requirements
- R1: After reset the control register reads 0x1 (cache disabled, discard mode, not busy), every line is invalid and `wb_valid` is low.
- R2: Control register (address 0): bit 0 is cache-disable and drives `cache_disable` (writing 0 enables the cache). Bit 1 is invalidate-mode (1 = write back dirty lines before invalidating). Bit 2 is the read-only busy bit, and writes to it have no effect.
- R3: Writing exactly 1 to address 1 starts a whole-cache flush, and writing exactly 1 to address 2 starts a whole-cache invalidate. Any other value written to these addresses starts nothing.
- R4: A whole-cache operation visits lines in ascending set order, with way 0 before way 1 within a set. A flush writes back each valid dirty line once, clears its dirty bit and keeps it valid. Busy stays 1 until the final writeback is acknowledged and reads 0 the cycle after.
- R5: A whole-cache invalidate in discard mode clears valid and dirty on every line and issues no writeback.
- R6: In write-back-first mode, invalidate writes back each dirty line before clearing it. Clean lines are invalidated without a writeback.
- R7: A per-line flush (address 3) or invalidate (address 4) takes its set from write-data bits [8:5] and ignores bits [4:0] and [31:9] of that write. The tag is bits [31:9] of the physical-tag register (address 5), whose lower bits are ignored and read back as 0. `wb_addr` is {tag, set, 5'b0}.
- R8: A per-line command leaves a line whose stored tag differs from the physical tag unchanged and issues no writeback for it.
- R9: While busy, any register write is held off with `reg_ready` low until the operation ends. Reads are always ready.
- R10: Once `wb_valid` is raised it stays high with a stable `wb_addr` until `wb_ready` is seen.
- R11: Install-port writes presented while busy are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| reg_valid | input | 1 | Register access request |
| reg_write | input | 1 | 1 = write, 0 = read |
| reg_addr | input | 3 | Register select |
| reg_wdata | input | 32 | Write data |
| reg_ready | output | 1 | Access accepted this cycle |
| reg_rdata | output | 32 | Read data, combinational on `reg_addr` |
| cache_disable | output | 1 | Cache-disable control bit |
| wb_valid | output | 1 | Writeback request |
| wb_ready | input | 1 | Writeback acknowledge |
| wb_addr | output | 32 | Line address to write back |
| fill_en | input | 1 | Install a line |
| fill_set | input | 4 | Install set |
| fill_way | input | 1 | Install way |
| fill_tag | input | 23 | Install tag |
| fill_dirty | input | 1 | Installed line is dirty |
| probe_set | input | 4 | Probe set |
| probe_way | input | 1 | Probe way |
| probe_valid | output | 1 | Probed line valid |
| probe_dirty | output | 1 | Probed line dirty |
| probe_tag | output | 23 | Probed line tag |

## Verification
The assertions rely on a writeback responder that may delay `wb_ready` but never raises it without a pending request. They also assume the register master holds a write request until it is accepted. The stall and start properties are phrased only over cycles in which the master keeps its request steady. The bench drives every register access through one task that keeps address and data fixed until `reg_ready`. Its responder raises `wb_ready` only in answer to `wb_valid`, and drops it after one cycle.

// File: rtl/dcm_pkg.sv
package dcm_pkg;
   localparam logic [2:0] RA_CTRL       = 3'd0;
   localparam logic [2:0] RA_FLUSH_ALL  = 3'd1;
   localparam logic [2:0] RA_INV_ALL    = 3'd2;
   localparam logic [2:0] RA_FLUSH_LINE = 3'd3;
   localparam logic [2:0] RA_INV_LINE   = 3'd4;
   localparam logic [2:0] RA_PTAG       = 3'd5;

   localparam int CTRL_OFF_BIT   = 0;
   localparam int CTRL_WBINV_BIT = 1;
   localparam int CTRL_BUSY_BIT  = 2;

   typedef struct packed {
      logic go;
      logic inv;
      logic whole;
      logic wbinv;
   } dcm_cmd_t;
endpackage

// File: rtl/dcm_regs.sv
module dcm_regs
   import dcm_pkg::*;
#(
   parameter int ADDR_W = 32,
   parameter int OFF_W  = 5,
   parameter int IDX_W  = 4,
   localparam int TAG_W = ADDR_W - OFF_W - IDX_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              reg_valid,
   input  logic              reg_write,
   input  logic [2:0]        reg_addr,
   input  logic [ADDR_W-1:0] reg_wdata,
   output logic              reg_ready,
   output logic [ADDR_W-1:0] reg_rdata,
   input  logic              busy,
   output logic              cache_disable,
   output dcm_cmd_t          cmd,
   output logic [IDX_W-1:0]  cmd_set,
   output logic [TAG_W-1:0]  cmd_tag
);
   logic             off_q, wbinv_q;
   logic [TAG_W-1:0] ptag_q;
   logic             wr_ok, one_val;

   assign reg_ready = !(reg_write && busy);
   assign wr_ok     = reg_valid && reg_write && !busy;
   assign one_val   = (reg_wdata == ADDR_W'(1));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         off_q   <= 1'b1;
         wbinv_q <= 1'b0;
         ptag_q  <= '0;
      end else if (wr_ok) begin
         if (reg_addr == RA_CTRL) begin
            off_q   <= reg_wdata[CTRL_OFF_BIT];
            wbinv_q <= reg_wdata[CTRL_WBINV_BIT];
         end
         if (reg_addr == RA_PTAG) ptag_q <= reg_wdata[ADDR_W-1 -: TAG_W];
      end
   end

   always_comb begin
      cmd.go    = wr_ok && (((reg_addr == RA_FLUSH_ALL || reg_addr == RA_INV_ALL) && one_val)
                            || reg_addr == RA_FLUSH_LINE || reg_addr == RA_INV_LINE);
      cmd.inv   = (reg_addr == RA_INV_ALL) || (reg_addr == RA_INV_LINE);
      cmd.whole = (reg_addr == RA_FLUSH_ALL) || (reg_addr == RA_INV_ALL);
      cmd.wbinv = wbinv_q;
   end

   assign cmd_set       = reg_wdata[OFF_W +: IDX_W];
   assign cmd_tag       = ptag_q;
   assign cache_disable = off_q;

   always_comb begin
      reg_rdata = '0;
      if (reg_addr == RA_CTRL) begin
         reg_rdata[CTRL_OFF_BIT]   = off_q;
         reg_rdata[CTRL_WBINV_BIT] = wbinv_q;
         reg_rdata[CTRL_BUSY_BIT]  = busy;
      end else if (reg_addr == RA_PTAG) begin
         reg_rdata[ADDR_W-1 -: TAG_W] = ptag_q;
      end
   end
endmodule

// File: rtl/dcm_tag_store.sv
module dcm_tag_store #(
   parameter int SETS  = 16,
   parameter int WAYS  = 2,
   parameter int TAG_W = 23,
   localparam int IDX_W = $clog2(SETS),
   localparam int WAY_W = (WAYS > 1) ? $clog2(WAYS) : 1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             busy,
   input  logic             fill_en,
   input  logic [IDX_W-1:0] fill_set,
   input  logic [WAY_W-1:0] fill_way,
   input  logic [TAG_W-1:0] fill_tag,
   input  logic             fill_dirty,
   input  logic [IDX_W-1:0] w_set,
   input  logic [WAY_W-1:0] w_way,
   input  logic             w_upd,
   input  logic             w_clr_valid,
   output logic             w_valid,
   output logic             w_dirty,
   output logic [TAG_W-1:0] w_tag,
   input  logic [IDX_W-1:0] p_set,
   input  logic [WAY_W-1:0] p_way,
   output logic             p_valid,
   output logic             p_dirty,
   output logic [TAG_W-1:0] p_tag
);
   logic             wv [WAYS];
   logic             wd [WAYS];
   logic [TAG_W-1:0] wt [WAYS];
   logic             pv [WAYS];
   logic             pd [WAYS];
   logic [TAG_W-1:0] pt [WAYS];
   logic             fill_ok;

   assign fill_ok = fill_en && !busy;

   for (genvar w = 0; w < WAYS; w++) begin : g_way
      logic [SETS-1:0]  vld_q, dty_q;
      logic [TAG_W-1:0] tag_q [SETS];
      logic             hit_w, hit_f;

      assign hit_w = w_upd && (w_way == WAY_W'(w));
      assign hit_f = fill_ok && (fill_way == WAY_W'(w));

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            vld_q <= '0;
            dty_q <= '0;
         end else if (hit_w) begin
            if (w_clr_valid) vld_q[w_set] <= 1'b0;
            dty_q[w_set] <= 1'b0;
         end else if (hit_f) begin
            vld_q[fill_set] <= 1'b1;
            dty_q[fill_set] <= fill_dirty;
         end
      end

      always_ff @(posedge clk) begin
         if (hit_f) tag_q[fill_set] <= fill_tag;
      end

      assign wv[w] = vld_q[w_set];
      assign wd[w] = dty_q[w_set];
      assign wt[w] = tag_q[w_set];
      assign pv[w] = vld_q[p_set];
      assign pd[w] = dty_q[p_set];
      assign pt[w] = tag_q[p_set];
   end

   assign w_valid = wv[w_way];
   assign w_dirty = wd[w_way];
   assign w_tag   = wt[w_way];
   assign p_valid = pv[p_way];
   assign p_dirty = pd[p_way];
   assign p_tag   = pt[p_way];
endmodule

// File: rtl/dcm_walker.sv
module dcm_walker
   import dcm_pkg::*;
#(
   parameter int SETS   = 16,
   parameter int WAYS   = 2,
   parameter int ADDR_W = 32,
   parameter int OFF_W  = 5,
   localparam int IDX_W = $clog2(SETS),
   localparam int WAY_W = (WAYS > 1) ? $clog2(WAYS) : 1,
   localparam int TAG_W = ADDR_W - OFF_W - IDX_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  dcm_cmd_t          cmd,
   input  logic [IDX_W-1:0]  cmd_set,
   input  logic [TAG_W-1:0]  cmd_tag,
   input  logic              ent_valid,
   input  logic              ent_dirty,
   input  logic [TAG_W-1:0]  ent_tag,
   output logic [IDX_W-1:0]  cur_set,
   output logic [WAY_W-1:0]  cur_way,
   output logic              upd_en,
   output logic              upd_clr_valid,
   output logic              busy,
   output logic              wb_valid,
   input  logic              wb_ready,
   output logic [ADDR_W-1:0] wb_addr
);
   typedef enum logic [1:0] {W_IDLE, W_SCAN, W_WB} wstate_e;

   wstate_e          state;
   logic             op_inv, op_whole, op_wbinv;
   logic [TAG_W-1:0] tag_q;
   logic             sel, need_wb, last, advance;

   assign sel     = ent_valid && (op_whole || ent_tag == tag_q);
   assign need_wb = sel && ent_dirty && (!op_inv || op_wbinv);
   assign last    = (cur_way == WAY_W'(WAYS - 1)) &&
                    (!op_whole || cur_set == IDX_W'(SETS - 1));
   assign advance = (state == W_SCAN && !need_wb) || (state == W_WB && wb_ready);

   assign upd_en        = (state == W_SCAN && sel && op_inv && !need_wb) ||
                          (state == W_WB && wb_ready);
   assign upd_clr_valid = op_inv;
   assign busy          = (state != W_IDLE);
   assign wb_valid      = (state == W_WB);
   assign wb_addr       = {ent_tag, cur_set, {OFF_W{1'b0}}};

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state    <= W_IDLE;
         cur_set  <= '0;
         cur_way  <= '0;
         op_inv   <= 1'b0;
         op_whole <= 1'b0;
         op_wbinv <= 1'b0;
         tag_q    <= '0;
      end else if (state == W_IDLE) begin
         if (cmd.go) begin
            state    <= W_SCAN;
            cur_set  <= cmd.whole ? '0 : cmd_set;
            cur_way  <= '0;
            op_inv   <= cmd.inv;
            op_whole <= cmd.whole;
            op_wbinv <= cmd.wbinv;
            tag_q    <= cmd_tag;
         end
      end else if (advance) begin
         if (last) begin
            state <= W_IDLE;
         end else begin
            state <= W_SCAN;
            if (cur_way == WAY_W'(WAYS - 1)) begin
               cur_way <= '0;
               cur_set <= cur_set + 1'b1;
            end else begin
               cur_way <= cur_way + 1'b1;
            end
         end
      end else if (need_wb) begin
         state <= W_WB;
      end
   end
endmodule

// File: rtl/dcache_maint_unit.sv
module dcache_maint_unit
   import dcm_pkg::*;
#(
   parameter int ADDR_W     = 32,
   parameter int SETS       = 16,
   parameter int WAYS       = 2,
   parameter int LINE_BYTES = 32,
   localparam int OFF_W = $clog2(LINE_BYTES),
   localparam int IDX_W = $clog2(SETS),
   localparam int WAY_W = (WAYS > 1) ? $clog2(WAYS) : 1,
   localparam int TAG_W = ADDR_W - OFF_W - IDX_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              reg_valid,
   input  logic              reg_write,
   input  logic [2:0]        reg_addr,
   input  logic [ADDR_W-1:0] reg_wdata,
   output logic              reg_ready,
   output logic [ADDR_W-1:0] reg_rdata,
   output logic              cache_disable,
   output logic              wb_valid,
   input  logic              wb_ready,
   output logic [ADDR_W-1:0] wb_addr,
   input  logic              fill_en,
   input  logic [IDX_W-1:0]  fill_set,
   input  logic [WAY_W-1:0]  fill_way,
   input  logic [TAG_W-1:0]  fill_tag,
   input  logic              fill_dirty,
   input  logic [IDX_W-1:0]  probe_set,
   input  logic [WAY_W-1:0]  probe_way,
   output logic              probe_valid,
   output logic              probe_dirty,
   output logic [TAG_W-1:0]  probe_tag
);
   if (SETS < 2 || (SETS & (SETS - 1)) != 0) begin : g_bad_sets
      $error("SETS must be a power of two of at least 2");
   end
   if (WAYS < 1 || (WAYS & (WAYS - 1)) != 0) begin : g_bad_ways
      $error("WAYS must be a power of two");
   end
   if (LINE_BYTES < 4 || (LINE_BYTES & (LINE_BYTES - 1)) != 0) begin : g_bad_line
      $error("LINE_BYTES must be a power of two of at least 4");
   end
   if (TAG_W < 1) begin : g_bad_tag
      $error("address too narrow for the geometry");
   end

   dcm_cmd_t         cmd_w;
   logic [IDX_W-1:0] cmd_set_w, cur_set_w;
   logic [TAG_W-1:0] cmd_tag_w, ent_tag_w;
   logic [WAY_W-1:0] cur_way_w;
   logic             busy_w, ent_valid_w, ent_dirty_w, upd_en_w, upd_clr_w;

   dcm_regs #(.ADDR_W(ADDR_W), .OFF_W(OFF_W), .IDX_W(IDX_W)) u_regs (
      .clk(clk), .rst_n(rst_n),
      .reg_valid(reg_valid), .reg_write(reg_write), .reg_addr(reg_addr),
      .reg_wdata(reg_wdata), .reg_ready(reg_ready), .reg_rdata(reg_rdata),
      .busy(busy_w), .cache_disable(cache_disable),
      .cmd(cmd_w), .cmd_set(cmd_set_w), .cmd_tag(cmd_tag_w)
   );

   dcm_walker #(.SETS(SETS), .WAYS(WAYS), .ADDR_W(ADDR_W), .OFF_W(OFF_W)) u_walk (
      .clk(clk), .rst_n(rst_n),
      .cmd(cmd_w), .cmd_set(cmd_set_w), .cmd_tag(cmd_tag_w),
      .ent_valid(ent_valid_w), .ent_dirty(ent_dirty_w), .ent_tag(ent_tag_w),
      .cur_set(cur_set_w), .cur_way(cur_way_w),
      .upd_en(upd_en_w), .upd_clr_valid(upd_clr_w), .busy(busy_w),
      .wb_valid(wb_valid), .wb_ready(wb_ready), .wb_addr(wb_addr)
   );

   dcm_tag_store #(.SETS(SETS), .WAYS(WAYS), .TAG_W(TAG_W)) u_store (
      .clk(clk), .rst_n(rst_n), .busy(busy_w),
      .fill_en(fill_en), .fill_set(fill_set), .fill_way(fill_way),
      .fill_tag(fill_tag), .fill_dirty(fill_dirty),
      .w_set(cur_set_w), .w_way(cur_way_w), .w_upd(upd_en_w), .w_clr_valid(upd_clr_w),
      .w_valid(ent_valid_w), .w_dirty(ent_dirty_w), .w_tag(ent_tag_w),
      .p_set(probe_set), .p_way(probe_way),
      .p_valid(probe_valid), .p_dirty(probe_dirty), .p_tag(probe_tag)
   );
endmodule

// File: rtl/dcm_checker.sv
module dcm_checker
   import dcm_pkg::*;
#(
   parameter int ADDR_W = 32,
   parameter int OFF_W  = 5
) (
   input logic              clk,
   input logic              rst_n,
   input logic              reg_valid,
   input logic              reg_write,
   input logic              reg_ready,
   input logic [2:0]        reg_addr,
   input logic [ADDR_W-1:0] reg_wdata,
   input logic              busy,
   input logic              wb_valid,
   input logic              wb_ready,
   input logic [ADDR_W-1:0] wb_addr
);
   AST_WB_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      wb_valid && !wb_ready |=> wb_valid && $stable(wb_addr)); // R10

   AST_WRITE_STALL: assert property (@(posedge clk) disable iff (!rst_n)
      busy && reg_valid && reg_write |-> !reg_ready); // R9

   AST_READ_READY: assert property (@(posedge clk) disable iff (!rst_n)
      reg_valid && !reg_write |-> reg_ready); // R9

   AST_WB_IN_OP: assert property (@(posedge clk) disable iff (!rst_n)
      wb_valid |-> busy); // R4

   AST_FLUSH_START: assert property (@(posedge clk) disable iff (!rst_n)
      reg_valid && reg_ready && reg_write && reg_addr == RA_FLUSH_ALL &&
      reg_wdata == ADDR_W'(1) |=> busy); // R3

   AST_NO_FALSE_START: assert property (@(posedge clk) disable iff (!rst_n)
      !busy && reg_valid && reg_write && reg_addr == RA_INV_ALL &&
      reg_wdata != ADDR_W'(1) |=> !busy); // R3

   AST_LINE_ALIGNED: assert property (@(posedge clk) disable iff (!rst_n)
      wb_valid |-> wb_addr[OFF_W-1:0] == '0); // R7
endmodule

bind dcache_maint_unit dcm_checker #(.ADDR_W(ADDR_W), .OFF_W(OFF_W)) u_chk (
   .clk(clk), .rst_n(rst_n),
   .reg_valid(reg_valid), .reg_write(reg_write), .reg_ready(reg_ready),
   .reg_addr(reg_addr), .reg_wdata(reg_wdata), .busy(busy_w),
   .wb_valid(wb_valid), .wb_ready(wb_ready), .wb_addr(wb_addr)
);

// File: tb/tb_dcache_maint_unit.sv
`timescale 1ns/1ps
module tb_dcache_maint_unit;
   localparam int AW = 32;
   localparam int IW = 4;
   localparam int WW = 1;
   localparam int TW = 23;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          reg_valid = 1'b0, reg_write = 1'b0;
   logic [2:0]    reg_addr = '0;
   logic [AW-1:0] reg_wdata = '0;
   logic          reg_ready;
   logic [AW-1:0] reg_rdata;
   logic          cache_disable, wb_valid;
   logic          wb_ready = 1'b0;
   logic [AW-1:0] wb_addr;
   logic          fill_en = 1'b0, fill_dirty = 1'b0;
   logic [IW-1:0] fill_set = '0, probe_set = '0;
   logic [WW-1:0] fill_way = '0, probe_way = '0;
   logic [TW-1:0] fill_tag = '0;
   logic          probe_valid, probe_dirty;
   logic [TW-1:0] probe_tag;

   always #2.5 clk = ~clk;

   dcache_maint_unit dut (
      .clk(clk), .rst_n(rst_n),
      .reg_valid(reg_valid), .reg_write(reg_write), .reg_addr(reg_addr),
      .reg_wdata(reg_wdata), .reg_ready(reg_ready), .reg_rdata(reg_rdata),
      .cache_disable(cache_disable),
      .wb_valid(wb_valid), .wb_ready(wb_ready), .wb_addr(wb_addr),
      .fill_en(fill_en), .fill_set(fill_set), .fill_way(fill_way),
      .fill_tag(fill_tag), .fill_dirty(fill_dirty),
      .probe_set(probe_set), .probe_way(probe_way),
      .probe_valid(probe_valid), .probe_dirty(probe_dirty), .probe_tag(probe_tag)
   );

   int errors = 0;
   int checks = 0;
   logic [AW-1:0] wb_log [16];
   int wb_n = 0;
   int ack_delay = 0;
   int ack_cnt = 0;
   int hold_bad = 0;
   logic [AW-1:0] hold_addr = '0;

   // writeback responder
   always @(negedge clk) begin
      if (wb_ready) begin
         wb_ready = 1'b0;
      end else if (wb_valid) begin
         if (ack_cnt > 0 && wb_addr !== hold_addr) hold_bad++;
         hold_addr = wb_addr;
         if (ack_cnt >= ack_delay) begin
            wb_ready = 1'b1;
            if (wb_n < 16) wb_log[wb_n] = wb_addr;
            wb_n++;
            ack_cnt = 0;
         end else begin
            ack_cnt++;
         end
      end
   end

   function automatic logic [AW-1:0] mk(input logic [TW-1:0] t, input logic [IW-1:0] s);
      return {t, s, 5'b0};
   endfunction

   task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic reg_wr(input logic [2:0] a, input logic [AW-1:0] d);
      @(negedge clk);
      reg_valid = 1'b1; reg_write = 1'b1; reg_addr = a; reg_wdata = d;
      #1;
      while (!reg_ready) begin @(negedge clk); #1; end
      @(posedge clk); #1;
      reg_valid = 1'b0; reg_write = 1'b0; reg_addr = '0;
   endtask

   task automatic rd(input logic [2:0] a, output logic [AW-1:0] d);
      reg_addr = a; #1;
      d = reg_rdata;
      reg_addr = '0;
   endtask

   task automatic busy_now(output logic b);
      logic [AW-1:0] v;
      rd(3'd0, v);
      b = v[2];
   endtask

   task automatic wait_idle(input string req);
      logic b;
      for (int i = 0; i < 2000; i++) begin
         @(negedge clk); #1;
         busy_now(b);
         if (!b) return;
      end
      chk(req, 1, 0);
   endtask

   task automatic fill_line(input logic [IW-1:0] s, input logic [WW-1:0] w,
                            input logic [TW-1:0] t, input logic d);
      @(negedge clk);
      fill_en = 1'b1; fill_set = s; fill_way = w; fill_tag = t; fill_dirty = d;
      @(negedge clk);
      fill_en = 1'b0;
   endtask

   task automatic look(input logic [IW-1:0] s, input logic [WW-1:0] w,
                       output logic v, output logic d, output logic [TW-1:0] t);
      probe_set = s; probe_way = w; #1;
      v = probe_valid; d = probe_dirty; t = probe_tag;
   endtask

   task automatic count_valid(output int n);
      logic v, d;
      logic [TW-1:0] t;
      n = 0;
      for (int s = 0; s < 16; s++)
         for (int w = 0; w < 2; w++) begin
            look(IW'(s), WW'(w), v, d, t);
            if (v) n++;
         end
   endtask

   task automatic clear_all();
      reg_wr(3'd0, 32'h0);
      reg_wr(3'd2, 32'h1);
      wait_idle("R5 clear");
   endtask

   task automatic t_reset();
      logic [AW-1:0] v;
      int n;
      rd(3'd0, v);
      chk("R1 ctrl", v, 32'h1);
      chk("R1 wb_valid", wb_valid, 0);
      chk("R1 cache_disable", cache_disable, 1);
      count_valid(n);
      chk("R1 lines valid", n, 0);
   endtask

   task automatic t_ctrl();
      logic [AW-1:0] v;
      reg_wr(3'd0, 32'h0);
      chk("R2 enable", cache_disable, 0);
      rd(3'd0, v);
      chk("R2 ctrl zero", v, 32'h0);
      reg_wr(3'd0, 32'h6);
      rd(3'd0, v);
      chk("R2 mode set busy ro", v, 32'h2);
      reg_wr(3'd0, 32'h0);
   endtask

   task automatic t_flush_all();
      logic b, v, d;
      logic [TW-1:0] t;
      clear_all();
      fill_line(4'd1, 1'b0, 23'h1A5, 1'b1);
      fill_line(4'd3, 1'b1, 23'h2B6, 1'b0);
      fill_line(4'd15, 1'b1, 23'h3C7, 1'b1);
      wb_n = 0; ack_delay = 2;
      reg_wr(3'd1, 32'h1);
      for (int i = 0; i < 500 && wb_n < 2; i++) begin @(negedge clk); #1; end
      busy_now(b);
      chk("R4 busy at last ack", b, 1);
      @(negedge clk); #1;
      busy_now(b);
      chk("R4 idle after last ack", b, 0);
      chk("R4 wb count", wb_n, 2);
      chk("R4 first wb", wb_log[0], mk(23'h1A5, 4'd1));
      chk("R4 second wb", wb_log[1], mk(23'h3C7, 4'd15));
      look(4'd1, 1'b0, v, d, t);
      chk("R4 kept valid", {v, d}, 2'b10);
      look(4'd15, 1'b1, v, d, t);
      chk("R4 kept valid last", {v, d}, 2'b10);
      look(4'd3, 1'b1, v, d, t);
      chk("R4 clean untouched", {v, d}, 2'b10);
      ack_delay = 0;
   endtask

   task automatic t_bad_trigger();
      logic b, v, d;
      logic [TW-1:0] t;
      clear_all();
      fill_line(4'd6, 1'b0, 23'h44, 1'b1);
      wb_n = 0;
      reg_wr(3'd1, 32'h2);
      reg_wr(3'd2, 32'h3);
      repeat (3) @(negedge clk);
      #1; busy_now(b);
      chk("R3 no start", b, 0);
      chk("R3 no wb", wb_n, 0);
      look(4'd6, 1'b0, v, d, t);
      chk("R3 line intact", {v, d}, 2'b11);
   endtask

   task automatic t_inv_discard();
      logic b;
      int n;
      reg_wr(3'd0, 32'h0);
      fill_line(4'd0, 1'b0, 23'h11, 1'b1);
      fill_line(4'd8, 1'b1, 23'h22, 1'b1);
      wb_n = 0;
      reg_wr(3'd2, 32'h1);
      busy_now(b);
      chk("R3 inv started", b, 1);
      wait_idle("R5 finish");
      chk("R5 no wb", wb_n, 0);
      count_valid(n);
      chk("R5 all invalid", n, 0);
   endtask

   task automatic t_inv_wb();
      int n;
      clear_all();
      reg_wr(3'd0, 32'h2);
      fill_line(4'd2, 1'b1, 23'hA0, 1'b1);
      fill_line(4'd9, 1'b0, 23'hB0, 1'b0);
      fill_line(4'd9, 1'b1, 23'hC0, 1'b1);
      wb_n = 0;
      reg_wr(3'd2, 32'h1);
      wait_idle("R6 finish");
      chk("R6 wb count", wb_n, 2);
      chk("R6 wb first", wb_log[0], mk(23'hA0, 4'd2));
      chk("R6 wb second", wb_log[1], mk(23'hC0, 4'd9));
      count_valid(n);
      chk("R6 all invalid", n, 0);
      reg_wr(3'd0, 32'h0);
   endtask

   task automatic t_line();
      logic [AW-1:0] r;
      logic v, d;
      logic [TW-1:0] t;
      clear_all();
      fill_line(4'd4, 1'b0, 23'h5A5A, 1'b1);
      fill_line(4'd4, 1'b1, 23'h6B6B, 1'b1);
      reg_wr(3'd5, mk(23'h5A5A, 4'hB) | 32'h1F);
      rd(3'd5, r);
      chk("R7 ptag low bits ignored", r, mk(23'h5A5A, 4'd0));
      wb_n = 0;
      reg_wr(3'd3, mk(23'h7777, 4'd4) | 32'h13);
      wait_idle("R7 flush line");
      chk("R7 wb count", wb_n, 1);
      chk("R7 wb addr", wb_log[0], mk(23'h5A5A, 4'd4));
      look(4'd4, 1'b0, v, d, t);
      chk("R7 flushed line", {v, d}, 2'b10);
      look(4'd4, 1'b1, v, d, t);
      chk("R7 other way intact", {v, d}, 2'b11);
      reg_wr(3'd5, mk(23'h6B6B, 4'd0));
      reg_wr(3'd4, mk(23'h0, 4'd4) | 32'h4);
      wait_idle("R7 inv line");
      look(4'd4, 1'b1, v, d, t);
      chk("R7 inv line discards", {v, d}, 2'b00);
      chk("R7 inv line no wb", wb_n, 1);
      look(4'd4, 1'b0, v, d, t);
      chk("R7 inv keeps other", v, 1);
   endtask

   task automatic t_mismatch();
      logic v, d;
      logic [TW-1:0] t;
      clear_all();
      fill_line(4'd10, 1'b0, 23'h3333, 1'b1);
      reg_wr(3'd0, 32'h2);
      reg_wr(3'd5, mk(23'h3332, 4'd0));
      wb_n = 0;
      reg_wr(3'd4, mk(23'h3333, 4'd10));
      wait_idle("R8 inv");
      reg_wr(3'd3, mk(23'h3333, 4'd10));
      wait_idle("R8 flush");
      chk("R8 no wb", wb_n, 0);
      look(4'd10, 1'b0, v, d, t);
      chk("R8 line unchanged", {v, d, t}, {2'b11, 23'h3333});
      reg_wr(3'd0, 32'h0);
   endtask

   task automatic t_stall();
      logic [AW-1:0] r;
      logic v, d, b;
      logic [TW-1:0] t;
      clear_all();
      fill_line(4'd15, 1'b1, 23'h4444, 1'b1);
      ack_delay = 6; wb_n = 0; hold_bad = 0;
      reg_wr(3'd1, 32'h1);
      @(negedge clk);
      reg_valid = 1'b1; reg_write = 1'b1; reg_addr = 3'd5; reg_wdata = mk(23'h5555, 4'd0);
      #1;
      chk("R9 write held", reg_ready, 0);
      reg_write = 1'b0; #1;
      chk("R9 read ready", reg_ready, 1);
      reg_valid = 1'b0; reg_addr = '0;
      fill_line(4'd0, 1'b1, 23'h5555, 1'b1);
      reg_wr(3'd5, mk(23'h5555, 4'd0));
      busy_now(b);
      chk("R9 accepted after idle", b, 0);
      rd(3'd5, r);
      chk("R9 ptag written", r, mk(23'h5555, 4'd0));
      chk("R10 address held", hold_bad, 0);
      chk("R10 wb count", wb_n, 1);
      look(4'd0, 1'b1, v, d, t);
      chk("R11 fill ignored", v, 0);
      ack_delay = 0;
   endtask

   initial begin
      #(5.0 * 150000);
      errors++; checks++;
      $display("FAIL watchdog: actual=timeout expected=done");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_ctrl();
      t_flush_all();
      t_bad_trigger();
      t_inv_discard();
      t_inv_wb();
      t_line();
      t_mismatch();
      t_stall();
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end
endmodule